// File: doc/BRIEF.md
# Indirect PHY Register Access Port

This block gives a host access to the 8-bit configuration registers of several PHY lanes through a single 32-bit access register. The host writes one packed command word. The word holds the operation (read or write), the lane number, a data byte and a 16-bit register address. The port then runs one transaction on a simple per-lane register bus. The bus has a shared address and write-data pair, a one-hot write strobe and a one-hot read enable for each lane, and a read-data byte coming back from each lane.

Each transaction occupies a fixed access window of `ACCESS_CYCLES` clock cycles, and a busy bit is high for that whole window. On a read, the byte from the lane is captured in the last cycle of the window and placed in the data field of the access register. Software updates part of a PHY register by issuing a read and then a write, because the port offers no atomic update. A command that arrives while the port is busy is discarded and raises a sticky error bit.

Top module: `phy_access_port`

## Requirements
- R1: After reset, `hostRdData` is 0 and no lane sees a write strobe or a read enable.
- R2: A command accepted with bit 31 = 1 (write) raises `phyWrEn` for the selected lane for exactly one cycle: the first cycle after the accepting edge. In that cycle `phyAddr` equals command bits 15:0 and `phyWrData` equals command bits 23:16.
- R3: A command accepted with bit 31 = 0 (read) holds `phyRdEn` of the selected lane high for the whole window. The lane's byte, as it stands in the last window cycle, then appears in `hostRdData[23:16]`.
- R4: Bit 30 of `hostRdData` (busy) rises on the edge that accepts a command and stays high for exactly `ACCESS_CYCLES` cycles.
- R5: A host write while busy is dropped, and the command in flight and its fields are unaffected. Bit 29 of `hostRdData` becomes 1 and stays 1 until reset.
- R6: The lane field is bits 28:24. A lane number of `LANES` or more produces no strobe on any lane, and a read to such a lane returns 0x00 in bits 23:16.
- R7: After a command completes, `hostRdData` holds the command's operation in bit 31, its lane in bits 28:24 and its address in bits 15:0. A write keeps its data byte in bits 23:16.
- R8: At most one lane sees any strobe in any cycle, and it is always the addressed lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for the access register |
| hostWrData | input | 32 | Command word |
| hostRdData | output | 32 | Access register readback: op, busy, error, lane, data, address |
| phyAddr | output | 16 | PHY register address, shared by all lanes |
| phyWrData | output | 8 | PHY write data, shared by all lanes |
| phyWrEn | output | LANES | One-hot write strobe per lane |
| phyRdEn | output | LANES | One-hot read enable per lane |
| phyRdData | input | 8*LANES | Read byte from each lane, lane 0 in the low byte |

## Verification
The bench builds the port with two lanes and a six-cycle access window. That makes it practical to count the busy cycles and the read-enable cycles one by one, and to place a second command in the middle of a window. The 5-bit lane field can still carry numbers 3 and 5, which reach past the last lane. The bench's lane model returns a byte derived from both the address and the lane. That way, a capture from the wrong lane or in the wrong cycle shows up as a wrong value.

// File: rtl/phy_access_pkg.sv
package phy_access_pkg;
  localparam int OP_BIT   = 31;
  localparam int BUSY_BIT = 30;
  localparam int ERR_BIT  = 29;
  localparam int LANE_LSB = 24;
  localparam int LANE_W   = 5;
  localparam int DATA_LSB = 16;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // accept host command this edge
    logic issue;    // first cycle of the access window
    logic capture;  // last cycle of the access window
    logic busy;     // window in progress
  } portCtl_t;
endpackage

// File: rtl/phy_access_ctrl.sv
module phy_access_ctrl
  import phy_access_pkg::*;
#(
  parameter int ACCESS_CYCLES = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostWrEn,
  output portCtl_t ctl,
  output logic     errFlag
);
  localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             first;
  logic             err;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      busy  <= 1'b0;
      first <= 1'b0;
      err   <= 1'b0;
    end else begin
      first <= hostWrEn && !busy;
      if (hostWrEn && !busy) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(ACCESS_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if (hostWrEn && busy) err <= 1'b1;
    end
  end

  always_comb begin
    ctl.load    = hostWrEn && !busy;
    ctl.issue   = first;
    ctl.capture = busy && (cnt == '0);
    ctl.busy    = busy;
  end

  assign errFlag = err;
endmodule

// File: rtl/phy_access_dp.sv
module phy_access_dp
  import phy_access_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  portCtl_t            ctl,
  input  logic                errFlag,
  input  logic [31:0]         hostWrData,
  output logic [31:0]         hostRdData,
  output logic [ADDR_W-1:0]   phyAddr,
  output logic [DATA_W-1:0]   phyWrData,
  output logic [LANES-1:0]    phyWrEn,
  output logic [LANES-1:0]    phyRdEn,
  input  logic [LANES*DATA_W-1:0] phyRdData
);
  logic              opReg;
  logic [LANE_W-1:0] laneReg;
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] laneByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= 1'b0;
      laneReg <= '0;
      dataReg <= '0;
      addrReg <= '0;
    end else if (ctl.load) begin
      opReg   <= hostWrData[OP_BIT];
      laneReg <= hostWrData[LANE_LSB +: LANE_W];
      dataReg <= hostWrData[DATA_LSB +: DATA_W];
      addrReg <= hostWrData[ADDR_W-1:0];
    end else if (ctl.capture && !opReg) begin
      dataReg <= laneByte;
    end
  end

  // lane mux; lanes beyond the last one read as zero
  always_comb begin
    laneByte = '0;
    for (int i = 0; i < LANES; i++)
      if (laneReg == LANE_W'(i)) laneByte = phyRdData[i*DATA_W +: DATA_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign phyWrEn[g] = ctl.issue && opReg  && (laneReg == LANE_W'(g));
    assign phyRdEn[g] = ctl.busy  && !opReg && (laneReg == LANE_W'(g));
  end

  assign phyAddr    = addrReg;
  assign phyWrData  = dataReg;
  assign hostRdData = {opReg, ctl.busy, errFlag, laneReg, dataReg, addrReg};
endmodule

// File: rtl/phy_access_port.sv
module phy_access_port
  import phy_access_pkg::*;
#(
  parameter int LANES         = 2,
  parameter int ACCESS_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostWrEn,
  input  logic [31:0]             hostWrData,
  output logic [31:0]             hostRdData,
  output logic [15:0]             phyAddr,
  output logic [7:0]              phyWrData,
  output logic [LANES-1:0]        phyWrEn,
  output logic [LANES-1:0]        phyRdEn,
  input  logic [LANES*8-1:0]      phyRdData
);
  portCtl_t ctl;
  logic     errFlag;

  phy_access_ctrl #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .ctl(ctl), .errFlag(errFlag)
  );

  phy_access_dp #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .errFlag(errFlag),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .phyAddr(phyAddr), .phyWrData(phyWrData),
    .phyWrEn(phyWrEn), .phyRdEn(phyRdEn), .phyRdData(phyRdData)
  );
endmodule

// File: rtl/phy_access_checker.sv
module phy_access_checker
  import phy_access_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWrEn,
  input logic [31:0]      hostRdData,
  input logic [LANES-1:0] phyWrEn,
  input logic [LANES-1:0] phyRdEn
);
  logic busyBit, errBit;
  logic [LANE_W-1:0] laneF;
  assign busyBit = hostRdData[BUSY_BIT];
  assign errBit  = hostRdData[ERR_BIT];
  assign laneF   = hostRdData[LANE_LSB +: LANE_W];

  assert_onehot_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({phyWrEn, phyRdEn}));

  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !busyBit) |=> busyBit);

  assert_write_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|phyWrEn) |=> !(|phyWrEn));

  assert_read_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|phyRdEn) |-> busyBit);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    errBit |=> errBit);

  assert_bad_lane_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(laneF) >= LANES) |-> ({phyWrEn, phyRdEn} == '0));
endmodule

bind phy_access_port phy_access_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdData(hostRdData),
  .phyWrEn(phyWrEn), .phyRdEn(phyRdEn)
);

// File: tb/sim_phy_access_port.sv
module sim_phy_access_port;
  localparam int LANES = 2;
  localparam int ACC   = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostWrEn = 1'b0;
  logic [31:0]       hostWrData = '0;
  logic [31:0]       hostRdData;
  logic [15:0]       phyAddr;
  logic [7:0]        phyWrData;
  logic [LANES-1:0]  phyWrEn, phyRdEn;
  logic [LANES*8-1:0] phyRdData;

  int checks = 0;
  int errors = 0;
  int wrCount [LANES];
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  phy_access_port #(.LANES(LANES), .ACCESS_CYCLES(ACC)) u0 (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .phyAddr(phyAddr), .phyWrData(phyWrData),
    .phyWrEn(phyWrEn), .phyRdEn(phyRdEn), .phyRdData(phyRdData)
  );

  // lane model: byte depends on address and lane
  function automatic logic [7:0] laneVal(int lane, logic [15:0] a);
    return a[7:0] ^ (lane == 0 ? 8'h3C : 8'hA5);
  endfunction
  for (genvar g = 0; g < LANES; g++) begin : g_model
    assign phyRdData[g*8 +: 8] = phyRdEn[g] ? laneVal(g, phyAddr) : 8'h00;
  end

  always @(posedge clk)
    for (int i = 0; i < LANES; i++) if (phyWrEn[i]) wrCount[i]++;

  function automatic logic [31:0] cmd(bit wr, int lane, logic [7:0] d, logic [15:0] a);
    return {wr, 2'b00, 5'(lane), d, a};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // returns at the negedge right after the accepting edge
  task automatic send(logic [31:0] c);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = c;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  // counts busy and strobe samples over the window, ends idle
  task automatic window(output int busyN, output int rdN, output int wrN);
    busyN = 0; rdN = 0; wrN = 0;
    for (int k = 0; k < ACC + 2; k++) begin
      if (hostRdData[30]) busyN++;
      if (|phyRdEn) rdN++;
      if (|phyWrEn) wrN++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 readback", hostRdData, 32'h0);
    chk("R1 strobes", {30'h0, phyWrEn}, 32'h0);
    chk("R1 rd enables", {30'h0, phyRdEn}, 32'h0);
  endtask

  task automatic t_write();
    int b, r, w, before0;
    before0 = wrCount[0];
    send(cmd(1, 1, 8'h5A, 16'h0067));
    chk("R2 one-hot write lane1", {30'h0, phyWrEn}, 32'h2);
    chk("R2 address", {16'h0, phyAddr}, 32'h0067);
    chk("R2 write data", {24'h0, phyWrData}, 32'h5A);
    @(negedge clk);
    chk("R2 single pulse", {30'h0, phyWrEn}, 32'h0);
    window(b, r, w);
    chk("R4 busy cycles (write)", b, ACC - 1);
    chk("R7 write readback", hostRdData, cmd(1, 1, 8'h5A, 16'h0067));
    chk("R8 lane0 untouched", wrCount[0], before0);
  endtask

  task automatic t_read(int lane, logic [15:0] a);
    int b, r, w;
    send(cmd(0, lane, 8'hFF, a));
    chk("R3 read enable lane", {30'h0, phyRdEn}, 32'(1 << lane));
    window(b, r, w);
    chk("R4 busy cycles", b, ACC);
    chk("R3 read enable cycles", r, ACC);
    chk("R3 readback", hostRdData, cmd(0, lane, laneVal(lane, a), a));
  endtask

  task automatic t_badLane();
    int b, r, w;
    send(cmd(0, 3, 8'h77, 16'h8070));
    window(b, r, w);
    chk("R6 no strobes on read", r + w, 0);
    chk("R6 read returns zero", hostRdData, cmd(0, 3, 8'h00, 16'h8070));
    send(cmd(1, 5, 8'h12, 16'h0065));
    window(b, r, w);
    chk("R6 no strobes on write", r + w, 0);
  endtask

  task automatic t_drop();
    int b, r, w;
    send(cmd(0, 0, 8'h00, 16'h0029));
    hostWrEn = 1'b1; hostWrData = cmd(1, 1, 8'hC3, 16'h0056);
    @(negedge clk);
    hostWrEn = 1'b0;
    chk("R5 busy not extended/error set", {29'h0, hostRdData[31:29]}, 32'h3);
    window(b, r, w);
    chk("R5 no write from dropped", w, 0);
    chk("R5 first command kept", hostRdData, cmd(0, 0, laneVal(0, 16'h0029), 16'h0029) | 32'h2000_0000);
    send(cmd(1, 0, 8'h11, 16'h0018));
    window(b, r, w);
    chk("R5 error stays set", hostRdData, cmd(1, 0, 8'h11, 16'h0018) | 32'h2000_0000);
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) wrCount[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_write();
    t_read(0, 16'h8065);
    t_read(1, 16'h80A4);
    t_badLane();
    t_drop();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule